// File: doc/BRIEF.md
# Packed Receive Byte FIFO

This block is the receive-side queue of a serial peripheral controller that runs with 8-bit frames. The shift register deposits each completed byte into a small circular byte store. Software or a DMA engine drains it over a register interface, one byte per read or, in packed mode, two bytes per half-word read. The store is 32 bits deep with the default parameters.

The block reports its occupancy in quarters of capacity. It raises a single receive-not-empty request, which feeds both the interrupt and the DMA request, against a threshold of one byte or two bytes. It also flags any byte that arrives when there is no room for it. The request is recomputed from the true remaining byte count after every read, packed or not. A half-word read that finds three bytes therefore leaves one byte and drops a two-byte request instead of raising it again. Read and write pointers stay aligned even when a byte arrives in the same cycle as a packed read.

Top module: `rxpk_fifo`

## Requirements
- R1: After synchronous reset the FIFO holds no bytes: `fill_lvl` is 0, `rxne` is 0, `ovr` is 0, and a read returns 16'h0000.
- R2: Bytes leave in arrival order. A read with `rd_half`=0 returns the oldest byte in `rd_data[7:0]` and zero in `rd_data[15:8]`, and removes exactly one byte.
- R3: `fill_lvl` encodes occupancy in quarters of capacity: 0 empty, 1 one quarter, 2 half, 3 three quarters, 4 full. With the default depth of 4 it equals the byte count.
- R4: With `thresh16`=0, `rxne` is 1 exactly when at least one byte is held. With `thresh16`=1 it is 1 exactly when at least two bytes are held. It reflects the occupancy left by the previous clock edge.
- R5: A read with `rd_half`=1 and `pack_en`=1 while two or more bytes are held returns the older byte in `rd_data[7:0]` and the next byte in `rd_data[15:8]`, and removes both.
- R6: A packed read taken at three-quarter occupancy leaves one-quarter occupancy. With `thresh16`=1, `rxne` is 0 afterwards, and the remaining byte is the newest of the three.
- R7: A packed read with exactly one byte held returns it in `rd_data[7:0]`, returns zero in `rd_data[15:8]`, and removes that byte.
- R8: A read with `rd_half`=1 and `pack_en`=0 behaves as a byte read: one byte is returned in the low lane and one byte is removed.
- R9: A read of an empty FIFO returns 16'h0000 and changes neither the occupancy nor the order of bytes pushed afterwards.
- R10: A push and a read in the same cycle both take effect and keep the order. A push into a full FIFO is accepted without overrun when the same cycle's read frees room.
- R11: A push into a full FIFO with no read in that cycle discards the new byte, leaves the stored bytes unchanged, and sets `ovr`. `ovr` stays set until cleared.
- R12: `ovr_clr` clears `ovr` at the next edge. A new overrun in the same cycle as `ovr_clr` leaves `ovr` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Shifter delivers a received byte this cycle |
| push_data | input | 8 | Received byte |
| rd_req | input | 1 | Register read of the data port this cycle |
| rd_half | input | 1 | Read is a half-word access (1) or a byte access (0) |
| pack_en | input | 1 | Packed mode: half-word reads return two bytes |
| thresh16 | input | 1 | Request threshold: 1 = two bytes, 0 = one byte |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 16 | Read data, valid combinationally during `rd_req` |
| fill_lvl | output | 3 | Occupancy in quarters (0..4) |
| rxne | output | 1 | Receive request for interrupt and DMA |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The clocked properties assume that `thresh16` and `pack_en` are not changed in the cycle right after a read, since the post-read request check compares against the threshold in force when the read was issued. They also assume that `push_data` is only meaningful while `push_valid` is high. The directed tasks change the mode and threshold inputs only while no read or push is in flight. Every push and read is applied on the falling clock edge for a single cycle, so each pop and push pair is seen exactly once.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    typedef enum logic [2:0] {
        LVL_EMPTY   = 3'd0,
        LVL_QUARTER = 3'd1,
        LVL_HALF    = 3'd2,
        LVL_THREEQ  = 3'd3,
        LVL_FULL    = 3'd4
    } fill_lvl_e;

    typedef struct packed {
        logic req;
        logic wide;
    } rd_access_t;

    function automatic fill_lvl_e quarters(int unsigned cnt, int unsigned depth);
        logic [2:0] q;
        q = 3'((cnt * 4) / depth);
        return fill_lvl_e'(q);
    endfunction

endpackage

// File: rtl/rxpk_store.sv
module rxpk_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic [1:0]    pop_n,
    output logic [DW-1:0] head0,
    output logic [DW-1:0] head1,
    output logic [CW-1:0] count
);
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [DW-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (wr_en && wr_ptr == PW'(i))
                slot[i] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(wr_en);
            rd_ptr <= rd_ptr + PW'(pop_n);
            count  <= count + CW'(wr_en) - CW'(pop_n);
        end
    end

    assign head0 = slot[rd_ptr];
    assign head1 = slot[rd_ptr + PW'(1)];

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R10
    ptr_align_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr - rd_ptr) == count[PW-1:0]);

    // R9
    pop_bound_chk: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_n) <= count);

endmodule

// File: rtl/rxpk_rdpath.sv
module rxpk_rdpath
    import rxpk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  rd_access_t      acc,
    input  logic [CW-1:0]   count,
    input  logic [DW-1:0]   head0,
    input  logic [DW-1:0]   head1,
    output logic [1:0]      pop_n,
    output logic [2*DW-1:0] rd_data
);
    always_comb begin
        pop_n   = 2'd0;
        rd_data = '0;
        if (acc.req && count != '0) begin
            if (acc.wide && count >= CW'(2)) begin
                pop_n   = 2'd2;
                rd_data = {head1, head0};
            end else begin
                pop_n   = 2'd1;
                rd_data = {{DW{1'b0}}, head0};
            end
        end
    end

    // R7
    lone_byte_chk: assert final (!(acc.req && count == CW'(1)) || pop_n == 2'd1);

endmodule

// File: rtl/rxpk_flags.sv
module rxpk_flags
    import rxpk_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          ovr_clr,
    input  logic          thresh16,
    input  logic [CW-1:0] count,
    input  logic [1:0]    pop_n,
    output logic          wr_en,
    output fill_lvl_e     fill_lvl,
    output logic          rxne,
    output logic          ovr
);
    logic [CW:0] after_pop;

    always_comb begin
        after_pop = {1'b0, count} - {{(CW-1){1'b0}}, pop_n};
        wr_en     = push && (after_pop < (CW+1)'(DEPTH));
        fill_lvl  = quarters(int'(count), DEPTH);
        rxne      = thresh16 ? (count >= CW'(2)) : (count != '0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ovr <= 1'b0;
        else if (push && !wr_en)
            ovr <= 1'b1;
        else if (ovr_clr)
            ovr <= 1'b0;
    end

    // R11
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr && !ovr_clr) |=> ovr);

    // R11
    full_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && pop_n == 2'd0) |-> !wr_en);

endmodule

// File: rtl/rxpk_fifo.sv
module rxpk_fifo
    import rxpk_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_valid,
    input  logic [DW-1:0]   push_data,
    input  logic            rd_req,
    input  logic            rd_half,
    input  logic            pack_en,
    input  logic            thresh16,
    input  logic            ovr_clr,
    output logic [2*DW-1:0] rd_data,
    output logic [2:0]      fill_lvl,
    output logic            rxne,
    output logic            ovr
);
    localparam int CW = $clog2(DEPTH + 1);

    initial begin
        if (DEPTH < 4 || DEPTH % 4 != 0 || (DEPTH & (DEPTH - 1)) != 0)
            $error("DEPTH must be a power of two and a multiple of 4");
    end

    rd_access_t    acc;
    logic [CW-1:0] cnt;
    logic [1:0]    pop_n;
    logic          wr_en;
    logic [DW-1:0] head0, head1;
    fill_lvl_e     lvl;

    assign acc.req  = rd_req;
    assign acc.wide = rd_half && pack_en;

    rxpk_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (push_data),
        .pop_n   (pop_n),
        .head0   (head0),
        .head1   (head1),
        .count   (cnt)
    );

    rxpk_rdpath #(.DEPTH(DEPTH), .DW(DW)) u_rdpath (
        .acc     (acc),
        .count   (cnt),
        .head0   (head0),
        .head1   (head1),
        .pop_n   (pop_n),
        .rd_data (rd_data)
    );

    rxpk_flags #(.DEPTH(DEPTH)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .push     (push_valid),
        .ovr_clr  (ovr_clr),
        .thresh16 (thresh16),
        .count    (cnt),
        .pop_n    (pop_n),
        .wr_en    (wr_en),
        .fill_lvl (lvl),
        .rxne     (rxne),
        .ovr      (ovr)
    );

    assign fill_lvl = lvl;

    // R5
    packed_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_half && pack_en && cnt >= CW'(2) && !push_valid)
        |=> (int'(cnt) == int'($past(cnt)) - 2));

    // R6
    threeq_rxne_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_half && pack_en && thresh16 && cnt == CW'(3) && !push_valid)
        |=> !rxne);

    // R9
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && cnt == '0 && !push_valid) |=> (cnt == '0));

    // R10
    push_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !(rd_half && pack_en) && cnt != '0 && push_valid)
        |=> $stable(cnt));

endmodule

// File: tb/rxpk_fifo_test.sv
module rxpk_fifo_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_valid = 1'b0;
    logic [7:0]  push_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_half = 1'b0;
    logic        pack_en = 1'b0;
    logic        thresh16 = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [15:0] rd_data;
    logic [2:0]  fill_lvl;
    logic        rxne;
    logic        ovr;

    int checks = 0;
    int fails  = 0;
    logic [15:0] got;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxpk_fifo uut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_data(push_data),
        .rd_req(rd_req), .rd_half(rd_half), .pack_en(pack_en),
        .thresh16(thresh16), .ovr_clr(ovr_clr), .rd_data(rd_data),
        .fill_lvl(fill_lvl), .rxne(rxne), .ovr(ovr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one cycle of stimulus; read data captured before the edge
    task automatic step(input bit p, input logic [7:0] d, input bit r, input bit h,
                        input bit clr = 1'b0);
        @(negedge clk);
        push_valid = p; push_data = d; rd_req = r; rd_half = h; ovr_clr = clr;
        #3 got = rd_data;
        @(posedge clk);
        #1;
        push_valid = 1'b0; rd_req = 1'b0; rd_half = 1'b0; ovr_clr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 level", int'(fill_lvl), 0);
        chk("R1 rxne", int'(rxne), 0);
        chk("R1 ovr", int'(ovr), 0);
        step(0, 8'h00, 1, 0);
        chk("R1 read", int'(got), 16'h0000);
    endtask

    task automatic t_byte_order;
        pack_en = 0; thresh16 = 0;
        step(1, 8'hA1, 0, 0);
        chk("R3 level one", int'(fill_lvl), 1);
        chk("R4 rxne 8-bit", int'(rxne), 1);
        thresh16 = 1; #1;
        chk("R4 rxne 16-bit one byte", int'(rxne), 0);
        step(1, 8'hA2, 0, 0);
        chk("R4 rxne 16-bit two bytes", int'(rxne), 1);
        step(1, 8'hA3, 0, 0);
        step(1, 8'hA4, 0, 0);
        chk("R3 level full", int'(fill_lvl), 4);
        step(0, 8'h00, 1, 0);
        chk("R2 first", int'(got), 16'h00A1);
        chk("R3 level 3/4", int'(fill_lvl), 3);
        step(0, 8'h00, 1, 0);
        chk("R2 second", int'(got), 16'h00A2);
        step(0, 8'h00, 1, 0);
        chk("R2 third", int'(got), 16'h00A3);
        step(0, 8'h00, 1, 0);
        chk("R2 fourth", int'(got), 16'h00A4);
        chk("R3 level empty", int'(fill_lvl), 0);
        thresh16 = 0;
    endtask

    task automatic t_packed;
        pack_en = 1; thresh16 = 1;
        for (int i = 1; i <= 4; i++) step(1, 8'(i * 8'h11), 0, 0);
        step(0, 8'h00, 1, 1);
        chk("R5 packed pair", int'(got), 16'h2211);
        chk("R5 level after", int'(fill_lvl), 2);
        chk("R5 rxne", int'(rxne), 1);
        step(0, 8'h00, 1, 1);
        chk("R5 packed pair 2", int'(got), 16'h4433);
        chk("R5 empty", int'(fill_lvl), 0);
    endtask

    task automatic t_threeq;
        pack_en = 1; thresh16 = 1;
        step(1, 8'h51, 0, 0);
        step(1, 8'h52, 0, 0);
        step(1, 8'h53, 0, 0);
        chk("R6 level 3/4", int'(fill_lvl), 3);
        step(0, 8'h00, 1, 1);
        chk("R6 data", int'(got), 16'h5251);
        chk("R6 level 1/4", int'(fill_lvl), 1);
        chk("R6 rxne low", int'(rxne), 0);
        step(0, 8'h00, 1, 1);
        chk("R7 lone byte", int'(got), 16'h0053);
        chk("R7 level", int'(fill_lvl), 0);
    endtask

    task automatic t_unpacked_half;
        pack_en = 0; thresh16 = 0;
        step(1, 8'h61, 0, 0);
        step(1, 8'h62, 0, 0);
        step(0, 8'h00, 1, 1);
        chk("R8 half unpacked", int'(got), 16'h0061);
        chk("R8 level", int'(fill_lvl), 1);
        step(0, 8'h00, 1, 0);
        chk("R8 next", int'(got), 16'h0062);
    endtask

    task automatic t_empty;
        pack_en = 1;
        step(0, 8'h00, 1, 1);
        chk("R9 data", int'(got), 0);
        chk("R9 level", int'(fill_lvl), 0);
        step(1, 8'h71, 0, 0);
        step(0, 8'h00, 1, 0);
        chk("R9 order kept", int'(got), 16'h0071);
    endtask

    task automatic t_simul;
        pack_en = 1; thresh16 = 0;
        step(1, 8'h81, 0, 0);
        step(1, 8'h82, 1, 0);
        chk("R10 data", int'(got), 16'h0081);
        chk("R10 level", int'(fill_lvl), 1);
        step(1, 8'h83, 1, 1);
        chk("R10 packed one", int'(got), 16'h0082);
        chk("R10 level 2", int'(fill_lvl), 1);
        step(1, 8'h84, 0, 0);
        step(1, 8'h85, 0, 0);
        step(1, 8'h86, 0, 0);
        step(1, 8'h87, 1, 1);
        chk("R10 full push+pop", int'(got), 16'h8483);
        chk("R10 level 3", int'(fill_lvl), 3);
        chk("R10 no ovr", int'(ovr), 0);
        step(0, 8'h00, 1, 1);
        chk("R10 pair", int'(got), 16'h8685);
        step(0, 8'h00, 1, 0);
        chk("R10 last", int'(got), 16'h0087);
    endtask

    task automatic t_overrun;
        pack_en = 1;
        for (int i = 1; i <= 4; i++) step(1, 8'(8'h90 + i), 0, 0);
        step(1, 8'h95, 0, 0);
        chk("R11 ovr set", int'(ovr), 1);
        chk("R11 level", int'(fill_lvl), 4);
        step(0, 8'h00, 0, 0);
        chk("R11 ovr held", int'(ovr), 1);
        step(0, 8'h00, 1, 1);
        chk("R11 data", int'(got), 16'h9291);
        step(0, 8'h00, 1, 1);
        chk("R11 discarded", int'(got), 16'h9493);
        chk("R11 ovr still", int'(ovr), 1);
        step(0, 8'h00, 0, 0, 1);
        chk("R12 cleared", int'(ovr), 0);
        for (int i = 1; i <= 4; i++) step(1, 8'(8'hB0 + i), 0, 0);
        step(1, 8'hBF, 0, 0, 1);
        chk("R12 set wins", int'(ovr), 1);
        step(0, 8'h00, 1, 1, 1);
        chk("R12 clear", int'(ovr), 0);
        step(0, 8'h00, 1, 1);
        chk("R12 drain", int'(fill_lvl), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_byte_order();
        t_packed();
        t_threeq();
        t_unpacked_half();
        t_empty();
        t_simul();
        t_overrun();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule